// File: doc/BRIEF.md
# Interrupt Status and Vector Logic

This block keeps the 16-bit event status word of a serial-bus master controller and turns it into one level interrupt line and two DMA request lines. Hardware event pulses from the bus engine and the data buffer set individual status bits. The buffer logic clears bits directly through a hardware clear vector. Software reaches the block through a simple register port with a single-cycle read strobe and a single-cycle write strobe.

Through that port, software reads the status word with the live bus-busy flag merged in, and writes the interrupt enable mask and the two DMA enable bits. It clears the clearable status bits by writing ones to them. It can also read a vector register, which returns the highest-priority pending enabled source and acknowledges it in the same access. In the newer register revision, a test-register write can force the low six status bits, so that interrupt paths can be exercised without bus traffic. The parameter `NEW_REV` selects the revision.

Register select codes on `reg_addr` are: 0 status, 1 enable mask, 2 vector, 3 DMA enables, 4 test. Reads of other codes return zero.

Top module: `isv_intr_status`

## Requirements
- R1: After reset, the status word, the enable mask, the DMA enables, the vector, `irq`, `dma_rx_req` and `dma_tx_req` all read as zero.
- R2: Each event input sets its own status bit at the next clock edge. The bits are: no-acknowledge 1, access-ready 2, receive-ready 3, transmit-ready 4, underflow 10, overrun 11, single-byte 15. A one in `hw_clr` clears the status bit at the same position.
- R3: `irq` is a register that is high when (status AND mask) was nonzero on the previous clock edge. It therefore rises one cycle after the status bit or mask bit that causes it.
- R4: `dma_rx_req` follows status bit 3 while DMA-enable bit 15 is set. `dma_tx_req` follows status bit 4 while DMA-enable bit 7 is set. Both are registered with the same one-cycle lag as `irq`.
- R5: A DMA-enable write stores only bits 15 and 7. In the same write, bit 15 set clears mask bit 3 and bit 7 set clears mask bit 4.
- R6: A vector read returns one plus the index of the lowest set bit of (status AND mask), or 0 when none is set. A nonzero result clears that status bit at the clock edge of the read.
- R7: A status write clears exactly the bits set in both the written value and 0x0027. Bits 3 and 4 and all other bits are unaffected.
- R8: On a status read, bit 12 equals the `bus_busy` input.
- R9: A mask write keeps bits 5:0 when `NEW_REV`=1 and bits 4:0 when `NEW_REV`=0.
- R10: With `NEW_REV`=1, a test write with bit 11 set forces status bits 5:0 to one. With `NEW_REV`=0, or with bit 11 clear, a test write has no effect on status.
- R11: When an event sets a bit in the same cycle as a software, hardware or vector clear of that bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (vector reads have a side effect) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from current state |
| evt_noack | input | 1 | No-acknowledge event |
| evt_acc_rdy | input | 1 | Access-ready event |
| evt_rx_rdy | input | 1 | Receive-ready event |
| evt_tx_rdy | input | 1 | Transmit-ready event |
| evt_under | input | 1 | Transmit underflow event |
| evt_over | input | 1 | Receive overrun event |
| evt_single | input | 1 | Single-byte event |
| hw_clr | input | 16 | Per-bit hardware clear from the buffer logic |
| bus_busy | input | 1 | Live bus-busy flag |
| irq | output | 1 | Level interrupt |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The hardest condition to reach from the ports is a status word with many sources pending at once, combined with an arbitrary mask. In that state the vector register must walk the enabled sources in ascending order and leave the others untouched. The bench reaches it with the test-register force, which sets all six low bits in one write. It then sweeps all 64 mask values and drains the vector register each time, comparing every returned index with the arithmetically expected ascending sequence. The same force drives a sweep over all 64 low-bit patterns of the status write, which confirms that the ready bits survive software clears.

// File: rtl/isv_pkg.sv
package isv_pkg;
    localparam int STAT_W = 16;
    localparam int VEC_W  = $clog2(STAT_W + 1);

    localparam int BIT_NOACK  = 1;
    localparam int BIT_ACCRDY = 2;
    localparam int BIT_RXRDY  = 3;
    localparam int BIT_TXRDY  = 4;
    localparam int BIT_UNDER  = 10;
    localparam int BIT_OVER   = 11;
    localparam int BIT_BUSY   = 12;
    localparam int BIT_SINGLE = 15;

    localparam int DMA_RX_BIT = 15;
    localparam int DMA_TX_BIT = 7;
    localparam int TEST_FORCE_BIT = 11;

    localparam logic [STAT_W-1:0] SW_CLR_MASK = 16'h0027;
    localparam logic [STAT_W-1:0] STORE_MASK  = 16'h8C3F;
    localparam logic [STAT_W-1:0] FORCE_MASK  = 16'h003F;
    localparam logic [STAT_W-1:0] DMA_KEEP    = 16'h8080;

    typedef enum logic [2:0] {
        SEL_STATUS = 3'd0,
        SEL_MASK   = 3'd1,
        SEL_VECTOR = 3'd2,
        SEL_DMA    = 3'd3,
        SEL_TEST   = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/isv_ctrl_regs.sv
module isv_ctrl_regs
    import isv_pkg::*;
#(
    parameter bit NEW_REV = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr,
    input  logic              dma_wr,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] mask_q,
    output logic [STAT_W-1:0] dma_q
);
    logic [STAT_W-1:0] keep;
    logic [STAT_W-1:0] dma_strip;

    generate
        if (NEW_REV) begin : g_wide_mask
            assign keep = 16'h003F;
        end else begin : g_narrow_mask
            assign keep = 16'h001F;
        end
    endgenerate

    always_comb begin
        dma_strip = '0;
        dma_strip[BIT_RXRDY] = wdata[DMA_RX_BIT];
        dma_strip[BIT_TXRDY] = wdata[DMA_TX_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            dma_q  <= '0;
        end else if (mask_wr) begin
            mask_q <= wdata & keep;
        end else if (dma_wr) begin
            dma_q  <= wdata & DMA_KEEP;
            mask_q <= mask_q & ~dma_strip;
        end
    end

    p_dma_strips_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_wr && !mask_wr && wdata[DMA_RX_BIT]) |=> !mask_q[BIT_RXRDY]);
    p_dma_strips_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_wr && !mask_wr && wdata[DMA_TX_BIT]) |=> !mask_q[BIT_TXRDY]);
endmodule

// File: rtl/isv_status_word.sv
module isv_status_word
    import isv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_in,
    input  logic [STAT_W-1:0] hw_clr,
    input  logic              sw_clr_en,
    input  logic [STAT_W-1:0] sw_clr_val,
    input  logic [STAT_W-1:0] ack_in,
    output logic [STAT_W-1:0] stat_q
);
    logic [STAT_W-1:0] clr_all;
    logic [STAT_W-1:0] stat_d;

    always_comb begin
        clr_all = hw_clr | ack_in;
        if (sw_clr_en) begin
            clr_all = clr_all | (sw_clr_val & SW_CLR_MASK);
        end
        stat_d = ((stat_q & ~clr_all) | set_in) & STORE_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    p_sw_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr_en && sw_clr_val[BIT_NOACK] && !set_in[BIT_NOACK]) |=> !stat_q[BIT_NOACK]);
    p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr_en && stat_q[BIT_RXRDY] && !hw_clr[BIT_RXRDY] && !ack_in[BIT_RXRDY])
        |=> stat_q[BIT_RXRDY]);
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set_in[BIT_NOACK] |=> stat_q[BIT_NOACK]);
endmodule

// File: rtl/isv_vector_enc.sv
module isv_vector_enc
    import isv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] pend,
    output logic [STAT_W-1:0] onehot,
    output logic [VEC_W-1:0]  idx
);
    logic [STAT_W:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < STAT_W; i++) begin : g_prio
            assign onehot[i]   = pend[i] & ~seen[i];
            assign seen[i + 1] = seen[i] | pend[i];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < STAT_W; i++) begin
            if (onehot[i]) begin
                idx = idx | VEC_W'(i + 1);
            end
        end
    end

    p_vec_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(onehot));
    p_vec_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0) |-> (idx != '0));
endmodule

// File: rtl/isv_out_stage.sv
module isv_out_stage
    import isv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat,
    input  logic [STAT_W-1:0] mask,
    input  logic              dma_rx_en,
    input  logic              dma_tx_en,
    output logic              irq_q,
    output logic              rx_req_q,
    output logic              tx_req_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q    <= 1'b0;
            rx_req_q <= 1'b0;
            tx_req_q <= 1'b0;
        end else begin
            irq_q    <= |(stat & mask);
            rx_req_q <= stat[BIT_RXRDY] & dma_rx_en;
            tx_req_q <= stat[BIT_TXRDY] & dma_tx_en;
        end
    end

    p_rx_req_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_req_q |-> $past(dma_rx_en));
    p_tx_req_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_q |-> $past(dma_tx_en));
    p_irq_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & mask) == '0) |=> !irq_q);
endmodule

// File: rtl/isv_intr_status.sv
module isv_intr_status
    import isv_pkg::*;
#(
    parameter bit NEW_REV = 1'b1,
    parameter int ADDR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              evt_noack,
    input  logic              evt_acc_rdy,
    input  logic              evt_rx_rdy,
    input  logic              evt_tx_rdy,
    input  logic              evt_under,
    input  logic              evt_over,
    input  logic              evt_single,
    input  logic [15:0]       hw_clr,
    input  logic              bus_busy,
    output logic              irq,
    output logic              dma_rx_req,
    output logic              dma_tx_req
);
    reg_sel_e          sel;
    logic [STAT_W-1:0] mask_q;
    logic [STAT_W-1:0] dma_q;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] pend;
    logic [STAT_W-1:0] onehot;
    logic [STAT_W-1:0] ack_vec;
    logic [VEC_W-1:0]  vec_idx;
    logic              wr_status;
    logic              wr_mask;
    logic              wr_dma;
    logic              wr_test;
    logic              force_low;
    logic [STAT_W-1:0] stat_view;

    assign sel       = reg_sel_e'(reg_addr[2:0]);
    assign wr_status = reg_wr && (sel == SEL_STATUS);
    assign wr_mask   = reg_wr && (sel == SEL_MASK);
    assign wr_dma    = reg_wr && (sel == SEL_DMA);
    assign wr_test   = reg_wr && (sel == SEL_TEST);
    assign force_low = NEW_REV && wr_test && reg_wdata[TEST_FORCE_BIT];

    always_comb begin
        set_vec = '0;
        set_vec[BIT_NOACK]  = evt_noack;
        set_vec[BIT_ACCRDY] = evt_acc_rdy;
        set_vec[BIT_RXRDY]  = evt_rx_rdy;
        set_vec[BIT_TXRDY]  = evt_tx_rdy;
        set_vec[BIT_UNDER]  = evt_under;
        set_vec[BIT_OVER]   = evt_over;
        set_vec[BIT_SINGLE] = evt_single;
        if (force_low) begin
            set_vec = set_vec | FORCE_MASK;
        end
    end

    assign pend    = stat_q & mask_q;
    assign ack_vec = (reg_rd && (sel == SEL_VECTOR)) ? onehot : '0;

    isv_ctrl_regs #(.NEW_REV(NEW_REV)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask_wr(wr_mask),
        .dma_wr (wr_dma),
        .wdata  (reg_wdata),
        .mask_q (mask_q),
        .dma_q  (dma_q)
    );

    isv_status_word u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_in    (set_vec),
        .hw_clr    (hw_clr),
        .sw_clr_en (wr_status),
        .sw_clr_val(reg_wdata),
        .ack_in    (ack_vec),
        .stat_q    (stat_q)
    );

    isv_vector_enc u_vec (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .onehot(onehot),
        .idx   (vec_idx)
    );

    isv_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat     (stat_q),
        .mask     (mask_q),
        .dma_rx_en(dma_q[DMA_RX_BIT]),
        .dma_tx_en(dma_q[DMA_TX_BIT]),
        .irq_q    (irq),
        .rx_req_q (dma_rx_req),
        .tx_req_q (dma_tx_req)
    );

    always_comb begin
        stat_view = stat_q;
        stat_view[BIT_BUSY] = bus_busy;
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_STATUS: reg_rdata = stat_view;
            SEL_MASK:   reg_rdata = mask_q;
            SEL_VECTOR: reg_rdata = STAT_W'(vec_idx);
            SEL_DMA:    reg_rdata = dma_q;
            default:    reg_rdata = '0;
        endcase
    end

    p_busy_view_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (sel == SEL_STATUS)) |-> (reg_rdata[BIT_BUSY] == bus_busy));
    p_vec_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (sel == SEL_VECTOR) && (vec_idx == VEC_W'(1)) && !set_vec[0])
        |=> !stat_q[0]);
endmodule

// File: tb/isv_intr_status_bench.sv
`timescale 1ns/1ps
module isv_intr_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [6:0]  ev = '0;
    logic [15:0] hw_clr = '0;
    logic        bus_busy = 1'b0;
    logic [15:0] rdata_n, rdata_o;
    logic        irq_n, irq_o, rxq_n, rxq_o, txq_n, txq_o;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    isv_intr_status #(.NEW_REV(1'b1)) u_isv_intr_status (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_n),
        .evt_noack(ev[0]), .evt_acc_rdy(ev[1]), .evt_rx_rdy(ev[2]),
        .evt_tx_rdy(ev[3]), .evt_under(ev[4]), .evt_over(ev[5]),
        .evt_single(ev[6]), .hw_clr(hw_clr), .bus_busy(bus_busy),
        .irq(irq_n), .dma_rx_req(rxq_n), .dma_tx_req(txq_n));

    isv_intr_status #(.NEW_REV(1'b0)) u_isv_intr_status_old (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_o),
        .evt_noack(ev[0]), .evt_acc_rdy(ev[1]), .evt_rx_rdy(ev[2]),
        .evt_tx_rdy(ev[3]), .evt_under(ev[4]), .evt_over(ev[5]),
        .evt_single(ev[6]), .hw_clr(hw_clr), .bus_busy(bus_busy),
        .irq(irq_o), .dma_rx_req(rxq_o), .dma_tx_req(txq_o));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] vn, output logic [15:0] vo);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        vn = rdata_n; vo = rdata_o;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse_ev(input int i);
        @(negedge clk);
        ev[i] = 1'b1;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic pulse_clr(input logic [15:0] v);
        @(negedge clk);
        hw_clr = v;
        @(negedge clk);
        hw_clr = '0;
    endtask

    function automatic int ev_bit(input int i);
        case (i)
            0: return 1;
            1: return 2;
            2: return 3;
            3: return 4;
            4: return 10;
            5: return 11;
            default: return 15;
        endcase
    endfunction

    task automatic cleanup();
        wr(3'd0, 16'hFFFF);
        pulse_clr(16'hFFFF);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] vn, vo, exp_s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, vn, vo); chk("R1 status new", vn, 0); chk("R1 status old", vo, 0);
        rd(3'd1, vn, vo); chk("R1 mask new", vn, 0); chk("R1 mask old", vo, 0);
        rd(3'd3, vn, vo); chk("R1 dma new", vn, 0); chk("R1 dma old", vo, 0);
        rd(3'd2, vn, vo); chk("R1 vector new", vn, 0);
        chk("R1 outputs", {13'd0, irq_n, rxq_n, txq_n}, 0);

        // R2 each event sets its bit, hw_clr clears it
        for (int i = 0; i < 7; i++) begin
            pulse_ev(i);
            rd(3'd0, vn, vo);
            chk("R2 event set new", vn, 16'(1) << ev_bit(i));
            chk("R2 event set old", vo, 16'(1) << ev_bit(i));
            pulse_clr(16'(1) << ev_bit(i));
            rd(3'd0, vn, vo);
            chk("R2 hw clear", vn, 0);
        end

        // R8 busy merge
        bus_busy = 1'b1;
        rd(3'd0, vn, vo); chk("R8 busy high", vn, 16'h1000);
        bus_busy = 1'b0;
        rd(3'd0, vn, vo); chk("R8 busy low", vn, 16'h0000);

        // R9 mask width per revision
        wr(3'd1, 16'hFFFF);
        rd(3'd1, vn, vo); chk("R9 mask new", vn, 16'h003F); chk("R9 mask old", vo, 16'h001F);
        wr(3'd1, 16'h0000);

        // R10 test force
        wr(3'd4, 16'hF7FF);
        rd(3'd0, vn, vo); chk("R10 no force bit", vn, 0);
        wr(3'd4, 16'h0800);
        rd(3'd0, vn, vo); chk("R10 force new", vn, 16'h003F); chk("R10 force old", vo, 0);
        cleanup();

        // R6 / R3 sweep over all masks
        for (int m = 0; m < 64; m++) begin
            wr(3'd1, 16'(m));
            wr(3'd4, 16'h0800);
            rd(3'd0, vn, vo);
            chk("R10 force in sweep", vn, 16'h003F);
            chk("R3 irq with mask", {15'd0, irq_n}, {15'd0, (m != 0)});
            chk("R3 irq old idle", {15'd0, irq_o}, 0);
            for (int b = 0; b < 6; b++) begin
                if (m[b]) begin
                    rd(3'd2, vn, vo);
                    chk("R6 vector order", vn, 16'(b + 1));
                end
            end
            rd(3'd2, vn, vo);
            chk("R6 vector drained", vn, 0);
            chk("R6 vector old", vo, 0);
            rd(3'd0, vn, vo);
            chk("R6 untouched bits", vn, 16'h003F & ~16'(m));
            cleanup();
        end
        wr(3'd1, 16'h0000);

        // R7 sweep over write patterns
        for (int k = 0; k < 64; k++) begin
            wr(3'd4, 16'h0800);
            wr(3'd0, {10'h3FF, 6'(k)});
            exp_s = 16'h003F & ~(16'(k) & 16'h0027);
            rd(3'd0, vn, vo);
            chk("R7 w1c subset", vn, exp_s);
            cleanup();
        end

        // R5 / R4 DMA enables
        wr(3'd1, 16'h003F);
        wr(3'd3, 16'hFFFF);
        rd(3'd3, vn, vo); chk("R5 dma keep new", vn, 16'h8080); chk("R5 dma keep old", vo, 16'h8080);
        rd(3'd1, vn, vo); chk("R5 mask strip new", vn, 16'h0027); chk("R5 mask strip old", vo, 16'h0007);
        pulse_ev(2);
        @(negedge clk);
        chk("R4 rx req", {13'd0, irq_n, rxq_n, txq_n}, 16'b010);
        pulse_ev(3);
        @(negedge clk);
        chk("R4 tx req", {13'd0, irq_n, rxq_n, txq_n}, 16'b011);
        wr(3'd3, 16'h0080);
        @(negedge clk);
        chk("R4 rx gated off", {13'd0, irq_n, rxq_n, txq_n}, 16'b001);
        pulse_clr(16'h0018);
        @(negedge clk);
        chk("R4 tx drops", {13'd0, irq_n, rxq_n, txq_n}, 16'b000);
        wr(3'd3, 16'h0000);

        // R3 latency
        wr(3'd1, 16'h0002);
        pulse_ev(0);
        chk("R3 irq not yet", {15'd0, irq_n}, 0);
        @(negedge clk);
        chk("R3 irq rises", {15'd0, irq_n}, 1);
        wr(3'd0, 16'h0002);
        chk("R3 irq still high", {15'd0, irq_n}, 1);
        @(negedge clk);
        chk("R3 irq falls", {15'd0, irq_n}, 0);
        wr(3'd1, 16'h0000);

        // R11 set wins over clear
        @(negedge clk);
        ev[0] = 1'b1; ev[2] = 1'b1; hw_clr = 16'h0008;
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h0002;
        @(negedge clk);
        ev = '0; hw_clr = '0; reg_wr = 1'b0;
        rd(3'd0, vn, vo);
        chk("R11 set wins new", vn, 16'h000A);
        chk("R11 set wins old", vo, 16'h000A);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule